// File: doc/BRIEF.md
# SPI Slave Byte Engine with Overrun Guard

This block is the receive and transmit datapath of an SPI slave. It runs on its own local clock, which has no fixed phase relation to the master. The serial clock, data-in and select inputs are brought into the local domain through synchronizer chains. The serial clock is then edge-detected by comparing two successive synchronized samples. Only one clock mode is handled: the serial clock idles low, MOSI is sampled on its rising edge, and MISO moves on its falling edge.

Each 8-bit frame is shifted in MSB first. A completed frame is placed in a receive holding register, and a full flag is raised. Software empties the register by pulsing a read strobe. If a frame completes while the holding register is still full, the unread byte is kept and the new byte is dropped. An overrun flag is then set, and it can be routed to an interrupt line. The outgoing byte is taken from a transmit input while no frame is running, and it goes out MSB first. The final count state of a frame lasts a single local clock, so the busy flag is free again well before the master starts the next frame.

The local clock must be fast enough to see every high and low phase of the serial clock. With two synchronizer stages, each phase must last at least four local clocks.

Top module: `spis_overrun_guard`

## Requirements
- R1: `xfer_busy` is low while idle. It rises only on the first synchronized rising serial-clock edge seen with select low, and it stays high through the rest of the frame.
- R2: A frame is 8 rising serial-clock edges. MOSI is sampled on each edge, and the first bit sampled becomes bit 7 of the byte. When the holding register is empty, the completed byte appears on `rx_byte` and `rx_full` goes to 1.
- R3: After the eighth rising edge, the count stays at its final value for exactly one local clock, and then the engine goes idle. Frames sent back to back under one select-low period are therefore each received correctly, and `xfer_busy` is low before the next frame's first edge.
- R4: `miso_d` carries `tx_byte` MSB first. The value is captured while no frame is running, bit 7 is presented before the first rising edge, and the output advances one bit after each falling edge within the frame.
- R5: If a frame completes while `rx_full` is 1 and no read strobe is present, `rx_byte` keeps the old byte and the new byte is discarded.
- R6: That overrun sets `ovr_flag`. The flag stays set until an `ovr_clr` pulse, and a new overrun in the same cycle as the clear wins.
- R7: A one-cycle `rd_stb` clears `rx_full` unless a frame completes in that cycle. If one does, the new byte is accepted and `rx_full` stays at 1.
- R8: A high synchronized select aborts any partial frame. The abort drops `xfer_busy`, delivers no byte, and holds `miso_oe` low while select is high.
- R9: `irq` is high exactly when `ovr_flag` is 1 and `irq_en` is 1.
- R10: After reset, `rx_full`, `ovr_flag`, `irq`, `xfer_busy` and `miso_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_in | input | 1 | Serial clock from the master (asynchronous) |
| mosi_in | input | 1 | Serial data from the master |
| ss_n_in | input | 1 | Slave select, active low |
| miso_d | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for the MISO pad driver |
| tx_byte | input | 8 | Byte to transmit in the next frame |
| rx_byte | output | 8 | Receive holding register |
| rx_full | output | 1 | Holding register contains an unread byte |
| rd_stb | input | 1 | Software read strobe, clears `rx_full` |
| xfer_busy | output | 1 | Frame in progress |
| ovr_flag | output | 1 | Overrun occurred |
| ovr_clr | input | 1 | Software clear of `ovr_flag` |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Overrun interrupt |

## Verification
The bench sweeps all 256 receive values and pairs each with a different transmit value. All frames are sent back to back under one select-low period. A design that held its final count state for longer, or shifted MISO on the wrong edge, would show a misaligned byte within a few frames.

An unread byte followed by a second frame checks that the old byte survives. A design that overwrote it would show the second byte instead. The same sequence checks the overrun flag, its interrupt gating and its clear.

A frame cut off by select going high must deliver nothing and must leave the next frame aligned. A design that kept its bit count across the abort would receive a shifted byte.

// File: rtl/spis_pkg.sv
// Shared types for the SPI slave byte engine.
package spis_pkg;

    // Raw or synchronized serial pins, packed in a fixed order for the synchronizer.
    typedef struct packed {
        logic sck;
        logic mosi;
        logic ss_n;
    } spis_pins_t;

    localparam int PINS_W = $bits(spis_pins_t);

endpackage

// File: rtl/spis_sync.sv
// Multi-bit flop-chain synchronizer.
// Each bit is an independent chain of STAGES flops. The chains are not
// coherent with each other; the callers rely only on per-bit settling.
// RST_VAL sets each bit's reset value, so that select can reset to
// the deselected state.
module spis_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the asynchronous bit through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d_async[b]};
        end

        assign q_sync[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spis_shifter.sv
// Frame engine: serial-clock edge detection, bit counter, receive shift
// register and transmit shift register.
// Assumes the inputs are already synchronized, and that every serial-clock
// phase lasts at least two local clocks after synchronization.
// The final count (DATA_W) lasts exactly one local clock.
module spis_shifter #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              ss_s,
    input  logic [DATA_W-1:0] tx_data,
    output logic              busy,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              sck_rise,
    output logic              frame_done,
    output logic [DATA_W-1:0] rx_word,
    output logic              miso_d,
    output logic              miso_oe
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

    logic              sck_q;
    logic              sck_fall;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    // Previous synchronized serial-clock sample, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise   = sck_s & ~sck_q;
    assign sck_fall   = ~sck_s & sck_q;
    assign frame_done = busy && (bit_cnt == LAST_CNT);

    // Frame sequencing: start on the first rising edge, count, finish, or abort on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
        end else if (ss_s) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            tx_sh   <= tx_data;
        end else if (frame_done) begin
            busy    <= 1'b0;
            bit_cnt <= '0;
            tx_sh   <= tx_data;
        end else if (!busy) begin
            tx_sh <= tx_data;
            if (sck_rise) begin
                busy    <= 1'b1;
                bit_cnt <= CNT_W'(1);
                rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
            end
        end else begin
            if (sck_rise) begin
                bit_cnt <= bit_cnt + CNT_W'(1);
                rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
            end
            if (sck_fall) begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rx_word = rx_sh;
    assign miso_d  = tx_sh[DATA_W-1];
    assign miso_oe = ~ss_s;

endmodule

// File: rtl/spis_rxbuf.sv
// Receive holding register with full flag, overrun guard and interrupt.
// A completed frame is accepted only when the register is empty or is
// being read in the same cycle. Otherwise the new word is dropped and
// the overrun flag is set. Setting the overrun flag wins over clearing it.
module spis_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [DATA_W-1:0] rx_word,
    input  logic              rd_stb,
    input  logic              ovr_clr,
    input  logic              irq_en,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              ovr,
    output logic              irq
);

    logic accept;
    logic overrun;

    assign accept  = frame_done && (!rx_full || rd_stb);
    assign overrun = frame_done && rx_full && !rd_stb;

    // Holding register and full flag: load on accept, empty on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
        end else if (accept) begin
            rx_data <= rx_word;
            rx_full <= 1'b1;
        end else if (rd_stb) begin
            rx_full <= 1'b0;
        end
    end

    // Sticky overrun flag; set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (overrun) ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end

    assign irq = ovr & irq_en;

endmodule

// File: rtl/spis_overrun_guard.sv
// SPI slave byte engine, top level.
// Mode: serial clock idles low, sampled on the rising edge.
// Assumes the local clock sees each serial-clock phase for at least
// SYNC_STAGES + 2 local clocks.
module spis_overrun_guard #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_in,
    input  logic              mosi_in,
    input  logic              ss_n_in,
    output logic              miso_d,
    output logic              miso_oe,
    input  logic [DATA_W-1:0] tx_byte,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_full,
    input  logic              rd_stb,
    output logic              xfer_busy,
    output logic              ovr_flag,
    input  logic              ovr_clr,
    input  logic              irq_en,
    output logic              irq
);
    import spis_pkg::*;

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam spis_pins_t PIN_RST = '{sck: 1'b0, mosi: 1'b0, ss_n: 1'b1};

    spis_pins_t        pins_raw;
    spis_pins_t        pins_s;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sck_rise;
    logic              frame_done;
    logic [DATA_W-1:0] rx_word;

    assign pins_raw = '{sck: sck_in, mosi: mosi_in, ss_n: ss_n_in};

    spis_sync #(
        .WIDTH   (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .q_sync  (pins_s)
    );

    spis_shifter #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s.sck),
        .mosi_s     (pins_s.mosi),
        .ss_s       (pins_s.ss_n),
        .tx_data    (tx_byte),
        .busy       (xfer_busy),
        .bit_cnt    (bit_cnt),
        .sck_rise   (sck_rise),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .miso_d     (miso_d),
        .miso_oe    (miso_oe)
    );

    spis_rxbuf #(
        .DATA_W (DATA_W)
    ) i_rxbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .rx_word    (rx_word),
        .rd_stb     (rd_stb),
        .ovr_clr    (ovr_clr),
        .irq_en     (irq_en),
        .rx_data    (rx_byte),
        .rx_full    (rx_full),
        .ovr        (ovr_flag),
        .irq        (irq)
    );

endmodule

// File: rtl/spis_guard_chk.sv
// Property checker for spis_overrun_guard, attached with bind.
module spis_guard_chk #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              sck_rise,
    input logic              frame_done,
    input logic              ss_sync,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_full,
    input logic              rd_stb,
    input logic              ovr
);

    AST_BUSY_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(sck_rise)); // R1

    AST_LAST_COUNT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == CNT_W'(DATA_W)) |=> (bit_cnt != CNT_W'(DATA_W))); // R3

    AST_UNREAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rd_stb) |=> $stable(rx_data)); // R5

    AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(rx_full)); // R6

    AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !frame_done) |=> !rx_full); // R7

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ss_sync |=> !busy); // R8

endmodule

bind spis_overrun_guard spis_guard_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) i_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (xfer_busy),
    .bit_cnt    (bit_cnt),
    .sck_rise   (sck_rise),
    .frame_done (frame_done),
    .ss_sync    (pins_s.ss_n),
    .rx_data    (rx_byte),
    .rx_full    (rx_full),
    .rd_stb     (rd_stb),
    .ovr        (ovr_flag)
);

// File: tb/test_spis_overrun_guard.sv
`timescale 1ns/1ps
// Bench for spis_overrun_guard: full byte sweep, overrun, abort.
module test_spis_overrun_guard;

    localparam int HALF = 6;   // local clocks per serial-clock phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_in = 1'b0;
    logic       mosi_in = 1'b0;
    logic       ss_n_in = 1'b1;
    logic       miso_d;
    logic       miso_oe;
    logic [7:0] tx_byte = '0;
    logic [7:0] rx_byte;
    logic       rx_full;
    logic       rd_stb = 1'b0;
    logic       xfer_busy;
    logic       ovr_flag;
    logic       ovr_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    spis_overrun_guard i_spis_overrun_guard (
        .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .mosi_in(mosi_in),
        .ss_n_in(ss_n_in), .miso_d(miso_d), .miso_oe(miso_oe),
        .tx_byte(tx_byte), .rx_byte(rx_byte), .rx_full(rx_full),
        .rd_stb(rd_stb), .xfer_busy(xfer_busy), .ovr_flag(ovr_flag),
        .ovr_clr(ovr_clr), .irq_en(irq_en), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame: drive m on MOSI, capture MISO at each rising edge.
    task automatic xfer(input logic [7:0] m, input logic [7:0] t,
                        input int nbits, output logic [7:0] got);
        got = '0;
        tx_byte = t;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi_in = m[i];
            tick(HALF);
            if (i == 7) chk("R1 idle before first edge", {31'd0, xfer_busy}, 32'd0);
            if (i == 3) chk("R1 busy mid-frame", {31'd0, xfer_busy}, 32'd1);
            got[i] = miso_d;
            sck_in = 1'b1;
            tick(HALF);
            sck_in = 1'b0;
        end
    endtask

    task automatic pulse_rd();
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        logic [7:0] t;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R10: reset state
        chk("R10 rx_full", {31'd0, rx_full}, 32'd0);
        chk("R10 ovr_flag", {31'd0, ovr_flag}, 32'd0);
        chk("R10 irq", {31'd0, irq}, 32'd0);
        chk("R10 busy", {31'd0, xfer_busy}, 32'd0);
        chk("R10 miso_oe", {31'd0, miso_oe}, 32'd0);

        ss_n_in = 1'b0;
        tick(4);
        chk("R8 miso_oe when selected", {31'd0, miso_oe}, 32'd1);

        // R2 R3 R4: all byte values back to back under one select
        for (int v = 0; v < 256; v++) begin
            t = 8'(v * 37 + 91);
            xfer(8'(v), t, 8, got);
            chk("R2 rx_byte", {24'd0, rx_byte}, {24'd0, 8'(v)});
            chk("R2 rx_full", {31'd0, rx_full}, 32'd1);
            chk("R4 miso byte", {24'd0, got}, {24'd0, t});
            pulse_rd();
            chk("R7 read clears full", {31'd0, rx_full}, 32'd0);
        end
        chk("R3 no overrun in sweep", {31'd0, ovr_flag}, 32'd0);

        // R5 R6 R9: overrun
        irq_en = 1'b1;
        xfer(8'h3C, 8'h00, 8, got);
        xfer(8'hC3, 8'h00, 8, got);
        chk("R5 old byte kept", {24'd0, rx_byte}, 32'h3C);
        chk("R5 still full", {31'd0, rx_full}, 32'd1);
        chk("R6 ovr set", {31'd0, ovr_flag}, 32'd1);
        chk("R9 irq enabled", {31'd0, irq}, 32'd1);
        irq_en = 1'b0;
        tick(1);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        tick(3);
        chk("R6 ovr sticky", {31'd0, ovr_flag}, 32'd1);
        ovr_clr = 1'b1;
        tick(1);
        ovr_clr = 1'b0;
        chk("R6 ovr cleared", {31'd0, ovr_flag}, 32'd0);
        pulse_rd();
        xfer(8'h5A, 8'hE1, 8, got);
        chk("R5 accepted after read", {24'd0, rx_byte}, 32'h5A);
        chk("R4 miso after overrun", {24'd0, got}, 32'hE1);
        chk("R6 no new ovr", {31'd0, ovr_flag}, 32'd0);
        pulse_rd();

        // R8: aborted partial frame
        xfer(8'hF0, 8'h00, 4, got);
        ss_n_in = 1'b1;
        tick(HALF);
        chk("R8 busy dropped", {31'd0, xfer_busy}, 32'd0);
        chk("R8 miso_oe off", {31'd0, miso_oe}, 32'd0);
        chk("R8 nothing delivered", {31'd0, rx_full}, 32'd0);
        ss_n_in = 1'b0;
        tick(4);
        xfer(8'h96, 8'h69, 8, got);
        chk("R8 realigned byte", {24'd0, rx_byte}, 32'h96);
        chk("R8 realigned miso", {24'd0, got}, 32'h69);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule